// File: doc/BRIEF.md
# Data Address Watchpoint Match Unit

This block watches the load and store stream of a processor pipeline against one programmable range of data addresses. Software sets a 64-bit watch address register and a 32-bit control register through a simple write port. Every access the pipeline presents is checked against these settings. The check uses the access's effective address, its size, its direction (load or store) and the privilege level it runs at.

The range starts at the watch address rounded down to a multiple of 8. Its length is 8 to 512 bytes and is set by a 6-bit count. The unit flags an access when any byte it touches falls inside the range, the access direction is enabled and the current privilege class is enabled.

The verdict is registered. In the cycle after the access is presented, either `hit_o` or `go_o` is raised, never both. The pipeline's commit stage lets the access update memory or registers only on `go_o`. A hit therefore suppresses the access before it takes effect, and a debug exception can be taken instead.

Top module: `dwatch_unit`

## Requirements
- R1: While reset is held, and after it is released, both registers read back as zero and `hit_o` and `go_o` are low. With zero registers no access can hit.
- R2: A write with `cfg_sel`=0 loads `cfg_wdata` into the watch address register. A write with `cfg_sel`=1 loads `cfg_wdata[31:0]` into the control register. Both read back unchanged on `addr_rd_o`/`ctrl_rd_o` from the next cycle. All 32 control bits are kept as written, including bit 7 (extended-match request), and bit 7 has no effect on matching.
- R3: The range base is the watch address with bits [2:0] cleared. The range length is (count+1)*8 bytes, where count is control bits [20:15].
- R4: An access covers bytes ea to ea+2^size-1, where `acc_size` holds log2 of the byte count (0..4 give 1..16 bytes, and 5..7 are treated as 16 bytes). The access matches when at least one of its bytes lies in the range, including accesses that straddle either edge. Address arithmetic does not wrap at the top of the address space.
- R5: A load can hit only when control bit 5 is set, and a store only when control bit 6 is set. With both bits clear nothing hits.
- R6: `acc_priv` 0 (user) is enabled by control bit 0, 1 (supervisor) by bit 1, and 2 (hypervisor) by bit 2. The value 3 is never enabled. With bits [2:0] all clear nothing hits.
- R7: For an access presented with `acc_valid` at clock edge N, `hit_o` is high during the cycle after edge N exactly when the access matches. `hit_o` is never high in a cycle that does not follow a valid access.
- R8: In that same cycle `go_o` is high exactly when the valid access did not hit. `hit_o` and `go_o` are never high together.
- R9: An access presented in the same cycle as a register write is judged against the old settings. Every access from the following cycle onward is judged against the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 watch address, 1 control |
| cfg_wdata | input | 64 | Write data (control register takes bits [31:0]) |
| addr_rd_o | output | 64 | Watch address register readback |
| ctrl_rd_o | output | 32 | Control register readback |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_ea | input | 64 | Effective address of the access |
| acc_size | input | 3 | log2 of the access byte count |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 hypervisor, 3 reserved |
| hit_o | output | 1 | Registered: previous access matched, suppress it |
| go_o | output | 1 | Registered: previous access is clear to commit |

## Verification
A register write and an access can land in the same cycle. The access must then be judged against the settings held before the write, and the next access against the new ones. The bench provokes this by presenting an access that hits under the old control value while it writes a control value that disables matching. It expects a hit for that access and no hit for an identical access one cycle later. It also runs the opposite case, where a write enables matching and only the second access hits. The expected verdicts come from the bench's own max/min overlap arithmetic.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  // control register field positions
  localparam int unsigned CNT_LSB   = 15;
  localparam int unsigned CNT_W     = 6;
  localparam int unsigned BIT_XMODE = 7;
  localparam int unsigned BIT_WEN   = 6;
  localparam int unsigned BIT_REN   = 5;
  localparam int unsigned BIT_HYP   = 2;
  localparam int unsigned BIT_SUP   = 1;
  localparam int unsigned BIT_USR   = 0;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_RSVD = 2'd3
  } priv_e;
endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      if (sel) ctrl_q <= wdata[CTRL_W-1:0];
      else     addr_q <= wdata;
    end
  end
endmodule

// File: rtl/dwatch_range_cmp.sv
module dwatch_range_cmp #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned MAX_LG = 4
) (
  input  logic [ADDR_W-1:0] watch_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] ea,
  input  logic [SIZE_W-1:0] size_lg,
  output logic              overlap_o
);
  localparam int unsigned EW = ADDR_W + 1;

  function automatic logic [EW-1:0] win_base(input logic [ADDR_W-1:0] a);
    return {1'b0, a[ADDR_W-1:3], 3'b000};
  endfunction

  function automatic logic [EW-1:0] win_end(input logic [EW-1:0] b,
                                            input logic [CNT_W-1:0] c);
    return b + ((EW'(c) + EW'(1)) << 3);
  endfunction

  function automatic logic [EW-1:0] acc_end(input logic [ADDR_W-1:0] a,
                                            input logic [SIZE_W-1:0] lg);
    logic [SIZE_W-1:0] l;
    l = (lg > SIZE_W'(MAX_LG)) ? SIZE_W'(MAX_LG) : lg;
    return {1'b0, a} + (EW'(1) << l);
  endfunction

  logic [EW-1:0] base_w, wend_w, aend_w, ea_w;

  always_comb begin
    base_w    = win_base(watch_addr);
    wend_w    = win_end(base_w, count);
    aend_w    = acc_end(ea, size_lg);
    ea_w      = {1'b0, ea};
    overlap_o = (ea_w < wend_w) && (base_w < aend_w);
  end
endmodule

// File: rtl/dwatch_qual.sv
module dwatch_qual
  import dwatch_pkg::*;
#(
  parameter int unsigned CTRL_W = 32
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              is_store,
  input  logic [1:0]        priv,
  output logic              type_ok_o,
  output logic              priv_ok_o,
  output logic              qual_o
);
  always_comb begin
    type_ok_o = is_store ? ctrl[BIT_WEN] : ctrl[BIT_REN];
    unique case (priv_e'(priv))
      PRIV_USER: priv_ok_o = ctrl[BIT_USR];
      PRIV_SUP:  priv_ok_o = ctrl[BIT_SUP];
      PRIV_HYP:  priv_ok_o = ctrl[BIT_HYP];
      default:   priv_ok_o = 1'b0;
    endcase
    qual_o = type_ok_o && priv_ok_o;
  end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned MAX_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] addr_rd_o,
  output logic [CTRL_W-1:0] ctrl_rd_o,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_ea,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_is_store,
  input  logic [1:0]        acc_priv,
  output logic              hit_o,
  output logic              go_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              range_hit_w;
  logic              type_ok_w, priv_ok_w, qual_ok_w;
  logic              match_w;

  dwatch_regs #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .addr_q(addr_q), .ctrl_q(ctrl_q)
  );

  dwatch_range_cmp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W),
                     .MAX_LG(MAX_LG)) cmp_i (
    .watch_addr(addr_q), .count(ctrl_q[CNT_LSB +: CNT_W]),
    .ea(acc_ea), .size_lg(acc_size), .overlap_o(range_hit_w)
  );

  dwatch_qual #(.CTRL_W(CTRL_W)) qual_i (
    .ctrl(ctrl_q), .is_store(acc_is_store), .priv(acc_priv),
    .type_ok_o(type_ok_w), .priv_ok_o(priv_ok_w), .qual_o(qual_ok_w)
  );

  assign match_w = acc_valid && range_hit_w && qual_ok_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o <= 1'b0;
      go_o  <= 1'b0;
    end else begin
      hit_o <= match_w;
      go_o  <= acc_valid && !match_w;
    end
  end

  assign addr_rd_o = addr_q;
  assign ctrl_rd_o = ctrl_q;
endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] addr_rd_o,
  input logic [CTRL_W-1:0] ctrl_rd_o,
  input logic              acc_valid,
  input logic              acc_is_store,
  input logic              range_hit,
  input logic              qual_ok,
  input logic              hit_o,
  input logic              go_o
);
  // R8: verdicts exclusive
  assert_hit_go_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && go_o));

  // R7: a verdict only follows a valid access
  assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit_o && !go_o);

  // R4: a hit needs the range comparator to have agreed
  assert_hit_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !range_hit |=> !hit_o);

  // R5: no direction enabled, no hit
  assert_no_dir_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd_o[6:5] == 2'b00 |=> !hit_o);

  // R6: no privilege class enabled, no hit
  assert_no_priv_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd_o[2:0] == 3'b000 |=> !hit_o);

  // R5: store with write enable clear never hits
  assert_store_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_is_store && !ctrl_rd_o[6] |=> !hit_o);

  // R2: control write is visible next cycle
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel |=> ctrl_rd_o == $past(cfg_wdata[CTRL_W-1:0]));

  // R2: address write is visible next cycle
  assert_addr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_sel |=> addr_rd_o == $past(cfg_wdata));

  // R7: a qualified in-range access hits
  assert_hit_when_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && range_hit && qual_ok |=> hit_o);
endmodule

bind dwatch_unit dwatch_unit_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .addr_rd_o(addr_rd_o), .ctrl_rd_o(ctrl_rd_o),
  .acc_valid(acc_valid), .acc_is_store(acc_is_store),
  .range_hit(range_hit_w), .qual_ok(qual_ok_w),
  .hit_o(hit_o), .go_o(go_o)
);

// File: tb/dwatch_unit_tb_top.sv
module dwatch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] addr_rd_o;
  logic [31:0] ctrl_rd_o;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_ea = '0;
  logic [2:0]  acc_size = '0;
  logic        acc_is_store = 1'b0;
  logic [1:0]  acc_priv = '0;
  logic        hit_o, go_o;

  int n_chk = 0;
  int n_bad = 0;

  // shadow of the programmed settings
  logic [63:0] sh_addr = '0;
  logic [31:0] sh_ctrl = '0;

  always #5 clk = ~clk;

  dwatch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_rd_o(addr_rd_o), .ctrl_rd_o(ctrl_rd_o),
    .acc_valid(acc_valid), .acc_ea(acc_ea), .acc_size(acc_size),
    .acc_is_store(acc_is_store), .acc_priv(acc_priv),
    .hit_o(hit_o), .go_o(go_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // overlap restated as max(lo) < min(hi)
  function automatic bit model_hit(input logic [63:0] wa, input logic [31:0] c,
                                   input logic [63:0] ea, input int lg,
                                   input bit st, input int pv);
    logic [64:0] b_lo, b_hi, a_lo, a_hi, lo, hi;
    int nbytes;
    bit dir_ok, pv_ok;
    dir_ok = st ? c[6] : c[5];
    case (pv)
      0: pv_ok = c[0];
      1: pv_ok = c[1];
      2: pv_ok = c[2];
      default: pv_ok = 1'b0;
    endcase
    nbytes = 1 << ((lg > 4) ? 4 : lg);
    b_lo = {1'b0, wa & ~64'd7};
    b_hi = b_lo + 65'(8 * (int'(c[20:15]) + 1));
    a_lo = {1'b0, ea};
    a_hi = a_lo + 65'(nbytes);
    lo = (a_lo > b_lo) ? a_lo : b_lo;
    hi = (a_hi < b_hi) ? a_hi : b_hi;
    return dir_ok && pv_ok && (lo < hi);
  endfunction

  task automatic wr(input bit sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (sel) sh_ctrl = d[31:0]; else sh_addr = d;
  endtask

  task automatic acc(input logic [63:0] ea, input int lg, input bit st,
                     input int pv, input string req);
    bit e;
    e = model_hit(sh_addr, sh_ctrl, ea, lg, st, pv);
    @(negedge clk);
    acc_valid = 1'b1; acc_ea = ea; acc_size = 3'(lg);
    acc_is_store = st; acc_priv = 2'(pv);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    check(hit_o == e, req, 64'(hit_o), 64'(e));
    check(go_o == !e, "R8", 64'(go_o), 64'(!e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk); #1;
    check(hit_o == 0 && go_o == 0, "R1", {62'd0, hit_o, go_o}, 0);
    check(addr_rd_o == 0, "R1", addr_rd_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(ctrl_rd_o == 0, "R1", 64'(ctrl_rd_o), 0);
    // R1: zero registers never hit
    for (int pv = 0; pv < 4; pv++) acc(64'h0, 3, pv[0], pv, "R1");

    // R2: readback, bit 7 kept
    wr(0, 64'hDEAD_BEEF_0123_4567);
    check(addr_rd_o == 64'hDEAD_BEEF_0123_4567, "R2", addr_rd_o, 64'hDEAD_BEEF_0123_4567);
    wr(1, 64'h0000_0000_A5A5_5AFF);
    check(ctrl_rd_o == 32'hA5A5_5AFF, "R2", 64'(ctrl_rd_o), 64'hA5A5_5AFF);

    // R3 R4 R5: sweeps over several counts, base misaligned by 5
    wr(0, 64'h45);
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic [31:0] c;
      int cnt;
      cnt = (cfg == 0) ? 0 : (cfg == 1) ? 1 : (cfg == 2) ? 5 : 63;
      c = 32'(cnt) << 15;
      c = c | 32'h7 | ((cfg == 1) ? 32'h20 : (cfg == 2) ? 32'h40 : 32'h60);
      if (cfg == 3) c = c | 32'h80;   // R2: extended-match bit ignored
      wr(1, 64'(c));
      for (int ea = 0; ea < ((cfg == 3) ? 640 : 160); ea++)
        for (int lg = 0; lg < 6; lg++)
          for (int st = 0; st < 2; st++)
            acc(64'(ea), lg, st[0], ea % 3, "R4");
    end

    // R5 R6: direction and privilege gating at a sure-overlap address
    wr(0, 64'h100);
    for (int m = 0; m < 32; m++) begin
      wr(1, 64'({m[4:3], 3'b000} | {27'd0, m[2:0]}) << 0 |
            64'(m[4:3]) << 5 | 64'(m[2:0]));
      for (int pv = 0; pv < 4; pv++)
        for (int st = 0; st < 2; st++)
          acc(64'h104, 0, st[0], pv, "R6");
    end

    // R4: top-of-address-space edge, no wrap
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 64'h67);
    acc(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2, "R4");
    acc(64'hFFFF_FFFF_FFFF_FFF0, 3, 1, 0, "R4");
    acc(64'h0, 4, 0, 1, "R4");

    // R7: idle cycle after a hit shows neither verdict
    wr(0, 64'h200);
    acc(64'h200, 0, 0, 0, "R7");
    @(posedge clk); #1;
    check(hit_o == 0 && go_o == 0, "R7", {62'd0, hit_o, go_o}, 0);

    // R9: write and access in the same cycle use old settings
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 64'h0;
    acc_valid = 1'b1; acc_ea = 64'h200; acc_size = 0; acc_is_store = 0; acc_priv = 0;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    check(hit_o == 1, "R9", 64'(hit_o), 1);
    sh_ctrl = 32'h0;
    acc(64'h200, 0, 0, 0, "R9");
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 64'h67;
    acc_valid = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    check(hit_o == 0 && go_o == 1, "R9", {62'd0, hit_o, go_o}, 1);
    sh_ctrl = 32'h67;
    acc(64'h200, 0, 0, 0, "R9");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule